// File: doc/BRIEF.md
# Dual-Read Single-Write General-Purpose Register File

This block is the architectural register storage of a single-cycle 32-bit integer datapath. It holds a parameterised set of general-purpose registers, 32 entries of 32 bits by default. Two read ports return register contents combinationally, each selected by its own index. One write port stores a data word into an indexed entry when its enable is high.

Writes take effect on the falling clock edge, not the rising one. A result that the datapath computes in the first half of a cycle is therefore stored at mid-cycle. A read of the same entry in the second half of that cycle already returns the new value, so the datapath needs no bypass path for this case. Entry 0 is a constant zero. A write addressed to it is discarded, and both read ports return zero for index 0.

An asynchronous active-low reset clears every entry. The block contains no decoding, no register naming and no hazard forwarding. Only the storage and the behaviour of its ports are covered.

Top module: `gpr_file_2r1w`

## Requirements
- R1: The file provides 32 registers of 32 bits. Each of indexes 1 to 31 holds its own value independently of the others.
- R2: A read at index 0 returns 32'h0000_0000 on either read port, even after a write of a nonzero value to index 0 with the write enable high.
- R3: When `wr_en` is 1, `wr_data` is stored into the entry selected by `wr_idx` on the falling edge of `clk`. A read of that entry before the falling edge returns the old value. A read after the falling edge, within the same cycle, returns the new value.
- R4: When `wr_en` is 0, no register changes, whatever `wr_idx` and `wr_data` carry.
- R5: The two read ports are independent. Each returns the entry selected by its own index in the same cycle, including when both select the same entry.
- R6: Read data follows the read index combinationally. A change of index changes the read data without any clock edge.
- R7: While `rst_n` is 0, every entry is forced to zero and writes are ignored. Every entry reads zero after `rst_n` returns to 1. Assertion of the reset takes effect without a clock edge.
- R8: A write changes only the addressed entry. All other entries keep their values.
- R9: The rising clock edge stores nothing. A write request raised after a falling edge and withdrawn before the next falling edge leaves the file unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes commit on its falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset. Clears all entries. |
| wr_en | input | 1 | Write enable for the write port. |
| wr_idx | input | 5 | Index of the entry to write. |
| wr_data | input | 32 | Data to store. |
| rd_idx_a | input | 5 | Index for read port A. |
| rd_data_a | output | 32 | Contents of the entry selected by `rd_idx_a`. |
| rd_idx_b | input | 5 | Index for read port B. |
| rd_data_b | output | 32 | Contents of the entry selected by `rd_idx_b`. |

## Verification
The bench samples a freshly written entry both before and after the falling edge of the same cycle. A design that stores on the rising edge shows the new value too early. A design with a registered read path shows it too late. A write to index 0 is followed by reads of index 0 on both ports, so an entry 0 that stores data shows up as a nonzero read. A write request that lives only across a rising edge checks that the rising edge stores nothing. Filling all 31 writable entries with distinct patterns and then reading them back through both ports exposes index-decode aliasing and writes that leak into neighbouring entries. A reset applied in mid-run, with a write held active during the reset, must leave every entry at zero.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;

  localparam int unsigned GPR_XLEN_DFLT  = 32;
  localparam int unsigned GPR_COUNT_DFLT = 32;

  // index width for a file of n entries (at least one bit)
  function automatic int unsigned gpr_idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned IDXW  = 5
) (
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  output logic [NREGS-1:1] wr_strobe
);

  // one strobe per writable entry; entry 0 has no strobe at all
  always_comb begin
    for (int unsigned k = 1; k < NREGS; k++) begin
      wr_strobe[k] = wr_en && (wr_idx == IDXW'(k));
    end
  end

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREGS-1:1]            wr_strobe,
  input  logic [XLEN-1:0]             wr_data,
  output logic [NREGS-1:0][XLEN-1:0]  regs_q
);

  // entry 0 is a constant, never a flop
  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_entry
    logic [XLEN-1:0] q;
    logic [XLEN-1:0] d;
    logic            en;

    // next-state: enable and data
    always_comb begin
      en = wr_strobe[g];
      d  = wr_data;
    end

    // state: committed on the falling clock edge
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign regs_q[g] = q;
  end

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDXW  = 5
) (
  input  logic [NREGS-1:0][XLEN-1:0] regs_q,
  input  logic [IDXW-1:0]            rd_idx,
  output logic [XLEN-1:0]            rd_data
);

  always_comb begin
    rd_data = '0;
    for (int unsigned k = 0; k < NREGS; k++) begin
      if (rd_idx == IDXW'(k)) begin
        rd_data = regs_q[k];
      end
    end
  end

endmodule

// File: rtl/gpr_file_2r1w.sv
module gpr_file_2r1w #(
  parameter int unsigned XLEN  = gpr_file_pkg::GPR_XLEN_DFLT,
  parameter int unsigned NREGS = gpr_file_pkg::GPR_COUNT_DFLT,
  localparam int unsigned IDXW = gpr_file_pkg::gpr_idx_width(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IDXW-1:0] rd_idx_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [XLEN-1:0] rd_data_b
);

  localparam int unsigned NRD = 2;

  logic [NREGS-1:1]           wr_strobe;
  logic [NREGS-1:0][XLEN-1:0] regs_q;
  logic [NRD-1:0][IDXW-1:0]   rd_idx_v;
  logic [NRD-1:0][XLEN-1:0]   rd_data_v;

  gpr_wr_decode #(.NREGS(NREGS), .IDXW(IDXW)) u_dec (
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_strobe (wr_strobe)
  );

  gpr_storage #(.NREGS(NREGS), .XLEN(XLEN)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .regs_q    (regs_q)
  );

  assign rd_idx_v[0] = rd_idx_a;
  assign rd_idx_v[1] = rd_idx_b;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gpr_read_port #(.NREGS(NREGS), .XLEN(XLEN), .IDXW(IDXW)) u_rd (
      .regs_q  (regs_q),
      .rd_idx  (rd_idx_v[p]),
      .rd_data (rd_data_v[p])
    );
  end

  assign rd_data_a = rd_data_v[0];
  assign rd_data_b = rd_data_v[1];

endmodule

// File: rtl/gpr_file_2r1w_chk.sv
module gpr_file_2r1w_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic [IDXW-1:0] rd_idx_a,
  input logic [XLEN-1:0] rd_data_a,
  input logic [IDXW-1:0] rd_idx_b,
  input logic [XLEN-1:0] rd_data_b
);

  // R2: index 0 reads zero on port A
  a_r2_zero_entry_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_a == '0) |-> (rd_data_a == '0));

  // R2: index 0 reads zero on port B
  a_r2_zero_entry_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_b == '0) |-> (rd_data_b == '0));

  // R3: by the rising edge, the mid-cycle write is visible on port A
  a_r3_same_cycle_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0 && rd_idx_a == wr_idx) |-> (rd_data_a == wr_data));

  // R3: same for port B
  a_r3_same_cycle_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0 && rd_idx_b == wr_idx) |-> (rd_data_b == wr_data));

  // R4: no write this cycle and same index -> same data
  a_r4_idle_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(rd_idx_a)) |-> $stable(rd_data_a));

  a_r4_idle_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(rd_idx_b)) |-> $stable(rd_data_b));

  // R7: while reset is held, both ports read zero
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_reset_clear: assert (rd_data_a == '0 && rd_data_b == '0);
    end
  end

endmodule

bind gpr_file_2r1w gpr_file_2r1w_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .rd_idx_a  (rd_idx_a),
  .rd_data_a (rd_data_a),
  .rd_idx_b  (rd_idx_b),
  .rd_data_b (rd_data_b)
);

// File: tb/gpr_file_2r1w_test.sv
module gpr_file_2r1w_test;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [4:0]  rd_idx_a;
  logic [31:0] rd_data_a;
  logic [4:0]  rd_idx_b;
  logic [31:0] rd_data_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  gpr_file_2r1w uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
  );

  // 50 MHz: 20 ns period, rising at 10, falling at 20
  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  // each row: drive after a rising edge, compare after the falling edge
  localparam vec_t VECS [10] = '{
    '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd0,  32'hA5A5_0001, 32'h0},
    '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd0,  32'h0,         32'h0},
    '{1'b1, 5'd31, 32'h8000_0000, 5'd31, 5'd5,  32'h8000_0000, 32'hA5A5_0001},
    '{1'b0, 5'd5,  32'h1234_5678, 5'd5,  5'd31, 32'hA5A5_0001, 32'h8000_0000},
    '{1'b1, 5'd6,  32'h0000_00FF, 5'd6,  5'd5,  32'h0000_00FF, 32'hA5A5_0001},
    '{1'b1, 5'd5,  32'hDEAD_BEEF, 5'd6,  5'd5,  32'h0000_00FF, 32'hDEAD_BEEF},
    '{1'b0, 5'd6,  32'h0,         5'd0,  5'd6,  32'h0,         32'h0000_00FF},
    '{1'b1, 5'd1,  32'h0000_0001, 5'd1,  5'd1,  32'h0000_0001, 32'h0000_0001},
    '{1'b1, 5'd1,  32'h0000_0002, 5'd31, 5'd1,  32'h8000_0000, 32'h0000_0002},
    '{1'b0, 5'd0,  32'hFFFF_FFFF, 5'd1,  5'd0,  32'h0000_0002, 32'h0}
  };

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b, ~b, b + 8'h40, 8'hC3};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(posedge clk);
    #2;
    wr_en = we; wr_idx = wa; wr_data = wd; rd_idx_a = ra; rd_idx_b = rb;
  endtask

  task automatic after_fall();
    @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx_a = 5'd3; rd_idx_b = 5'd17;
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check("R7 reset state port A", rd_data_a, 32'h0);
    check("R7 reset state port B", rd_data_b, 32'h0);
    rst_n = 1'b1;

    // vector table
    foreach (VECS[i]) begin
      drive(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].ra, VECS[i].rb);
      after_fall();
      check("R2/R3/R4/R5/R8 table port A", rd_data_a, VECS[i].ea);
      check("R2/R3/R4/R5/R8 table port B", rd_data_b, VECS[i].eb);
    end

    // R3: before the falling edge old value, after it the new one
    drive(1'b1, 5'd7, 32'h7777_0007, 5'd7, 5'd2);
    #3;
    check("R3 before falling edge", rd_data_a, 32'h0);
    after_fall();
    check("R3 after falling edge", rd_data_a, 32'h7777_0007);

    // R1/R8: fill all writable entries with distinct patterns
    for (int i = 1; i < 32; i++) begin
      drive(1'b1, 5'(i), pat(i), 5'(i), 5'd0);
    end
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    after_fall();
    for (int i = 0; i < 32; i++) begin
      rd_idx_a = 5'(i);
      rd_idx_b = 5'(31 - i);
      #1;
      check("R1 readback port A", rd_data_a, (i == 0) ? 32'h0 : pat(i));
      check("R5 readback port B", rd_data_b, (i == 31) ? 32'h0 : pat(31 - i));
    end

    // R6: index change without a clock edge
    @(posedge clk);
    #3;
    rd_idx_a = 5'd3;
    #1 check("R6 combinational read", rd_data_a, pat(3));
    rd_idx_a = 5'd4;
    #1 check("R6 combinational read", rd_data_a, pat(4));

    // R2: write to index 0 while reading it on both ports
    drive(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    after_fall();
    check("R2 index 0 port A", rd_data_a, 32'h0);
    check("R2 index 0 port B", rd_data_b, 32'h0);

    // R9: request spans only a rising edge
    @(negedge clk);
    #2;
    wr_en = 1'b1; wr_idx = 5'd10; wr_data = 32'hCAFE_F00D; rd_idx_a = 5'd11; rd_idx_b = 5'd12;
    @(posedge clk);
    #2;
    wr_en = 1'b0;
    after_fall();
    rd_idx_a = 5'd10;
    #1 check("R9 rising edge stores nothing", rd_data_a, pat(10));

    // R4: idle cycles with garbage on the write port
    drive(1'b0, 5'd9, 32'h0BAD_0BAD, 5'd9, 5'd8);
    after_fall();
    check("R4 disabled write port A", rd_data_a, pat(9));
    check("R4 disabled write port B", rd_data_b, pat(8));

    // R7: reset mid-run, with a write held active
    drive(1'b1, 5'd9, 32'h1111_2222, 5'd9, 5'd20);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R7 async clear port A", rd_data_a, 32'h0);
    check("R7 async clear port B", rd_data_b, 32'h0);
    wr_en = 1'b1;
    after_fall();
    check("R7 write ignored in reset", rd_data_a, 32'h0);
    @(posedge clk);
    #2;
    wr_en = 1'b0;
    rst_n = 1'b1;
    after_fall();
    check("R7 cleared after release A", rd_data_a, 32'h0);
    check("R7 cleared after release B", rd_data_b, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule